// File: doc/BRIEF.md
# ADC Sample Format Converter

This block takes raw converter samples of a configurable width and turns them into a signed word padded to a whole number of bytes. Format conversion can be switched on or off. When it is on, a type select declares the incoming code as offset binary or two's complement. Offset-binary codes are turned into two's complement by inverting the top bit. Two's-complement samples can also be sign-extended into the padding bits. A static signed 16-bit DC correction is then added, and the sum is clamped to the sample range instead of wrapping.

Samples arrive with a valid strobe and leave two clock cycles later with a matching strobe. The first register stage does the code conversion. The second stage adds the offset, saturates the sum and fills the padding. All control inputs are captured together with the sample they apply to, so each result depends only on the controls present in its input cycle. The output word holds its value while no new result is presented.

The datapath is a fixed pipeline with no state machine. Its only modes come from the control inputs. The padding rule is held as a two-value enumeration: zero fill or sign fill.

Top module: `adc_sample_fmt`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_data` are 0.
- R2: `out_valid` equals `in_valid` delayed by exactly two clock cycles, and back-to-back samples are accepted every cycle.
- R3: With `fmt_en` = 0, the type and sign-extension selects have no effect: the low SAMPLE_W bits carry the sample and the padding bits are 0, apart from any DC correction (R7).
- R4: With `fmt_en` = 1 and `ob_sel` = 1, the sample is offset binary, and bit SAMPLE_W-1 is inverted to give two's complement. Sign extension is not applied and the padding is 0.
- R5: With `fmt_en` = 1, `ob_sel` = 0 and `sext_en` = 1, every padding bit (OUT_W-1 down to SAMPLE_W) copies the result's bit SAMPLE_W-1.
- R6: With `fmt_en` = 1, `ob_sel` = 0 and `sext_en` = 0, the padding bits are 0.
- R7: With `dc_en` = 1, `dc_ofs` is treated as a 16-bit two's-complement number and added to the sample. The sample's bit SAMPLE_W-1 is its sign.
- R8: The sum is clamped to the range from -2^(SAMPLE_W-1) to 2^(SAMPLE_W-1)-1 and never wraps.
- R9: With `dc_en` = 0, `dc_ofs` has no effect. A zero offset with `dc_en` = 1 leaves the sample unchanged.
- R10: `out_data` keeps its value in every cycle in which `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | SAMPLE_W | Raw sample code |
| fmt_en | input | 1 | Enables format conversion |
| ob_sel | input | 1 | 1 = offset binary, 0 = two's complement |
| sext_en | input | 1 | Sign-fill the padding (two's complement only) |
| dc_en | input | 1 | Enables DC offset addition |
| dc_ofs | input | 16 | Signed DC offset |
| out_valid | output | 1 | Result strobe |
| out_data | output | OUT_W | Converted, byte-aligned result |

## Verification
On every cycle, the assertions check the two-cycle strobe delay, the hold of the output between results, the reset values and the padding rule: the padding is either all zeros or a copy of the result's top bit. They also check that with both enables off the sample passes through untouched. The correct inversion of offset-binary codes, the offset arithmetic and the exact clamp values at both limits can only be shown by the bench's scenarios, where a behavioural model predicts each result.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

    localparam int OFS_W = 16;

    typedef struct packed {
        logic             fmt_en;
        logic             ob_sel;
        logic             sext_en;
        logic             dc_en;
        logic [OFS_W-1:0] dc_ofs;
    } fmt_ctrl_t;

    typedef enum logic {
        PAD_ZERO = 1'b0,
        PAD_SIGN = 1'b1
    } pad_mode_e;

endpackage

// File: rtl/adc_fmt_conv.sv
module adc_fmt_conv
    import adc_fmt_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    input  fmt_ctrl_t           ctrl,
    output logic                cv_valid,
    output logic [SAMPLE_W-1:0] cv_data,
    output pad_mode_e           cv_pad,
    output logic                cv_dc_on,
    output logic [OFS_W-1:0]    cv_ofs
);

    logic                flip_msb;
    logic [SAMPLE_W-1:0] conv;
    pad_mode_e           pad_next;

    always_comb begin
        flip_msb = ctrl.fmt_en & ctrl.ob_sel;
        conv     = {in_data[SAMPLE_W-1] ^ flip_msb, in_data[SAMPLE_W-2:0]};
        pad_next = (ctrl.fmt_en && !ctrl.ob_sel && ctrl.sext_en) ? PAD_SIGN : PAD_ZERO;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cv_valid <= 1'b0;
            cv_data  <= '0;
            cv_pad   <= PAD_ZERO;
            cv_dc_on <= 1'b0;
            cv_ofs   <= '0;
        end else begin
            cv_valid <= in_valid;
            if (in_valid) begin
                cv_data  <= conv;
                cv_pad   <= pad_next;
                cv_dc_on <= ctrl.dc_en && (ctrl.dc_ofs != '0);
                cv_ofs   <= ctrl.dc_ofs;
            end
        end
    end

endmodule

// File: rtl/adc_ofs_sat.sv
module adc_ofs_sat
    import adc_fmt_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int OUT_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cv_valid,
    input  logic [SAMPLE_W-1:0] cv_data,
    input  pad_mode_e           cv_pad,
    input  logic                cv_dc_on,
    input  logic [OFS_W-1:0]    cv_ofs,
    output logic                out_valid,
    output logic [OUT_W-1:0]    out_data
);

    localparam int WIDE_W = (SAMPLE_W > OFS_W) ? SAMPLE_W : OFS_W;
    localparam int SUM_W  = WIDE_W + 1;
    localparam int PAD_W  = OUT_W - SAMPLE_W;
    localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((64'sd1 <<< (SAMPLE_W - 1)) - 64'sd1);
    localparam logic signed [SUM_W-1:0] SAT_LO = ~SAT_HI;

    logic signed [SUM_W-1:0] smp_w, ofs_w, sum_w, clamp_w;
    logic [SAMPLE_W-1:0]     res;
    logic [OUT_W-1:0]        word;

    always_comb begin
        smp_w = SUM_W'(signed'(cv_data));
        ofs_w = SUM_W'(signed'(cv_ofs));
        sum_w = cv_dc_on ? (smp_w + ofs_w) : smp_w;
        if (sum_w > SAT_HI)      clamp_w = SAT_HI;
        else if (sum_w < SAT_LO) clamp_w = SAT_LO;
        else                     clamp_w = sum_w;
        res = clamp_w[SAMPLE_W-1:0];
    end

    generate
        if (PAD_W > 0) begin : g_pad
            logic [PAD_W-1:0] pad_bits;
            always_comb begin
                unique case (cv_pad)
                    PAD_SIGN: pad_bits = {PAD_W{res[SAMPLE_W-1]}};
                    PAD_ZERO: pad_bits = '0;
                    default:  pad_bits = '0;
                endcase
                word = {pad_bits, res};
            end
        end else begin : g_nopad
            always_comb word = res;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= cv_valid;
            if (cv_valid) out_data <= word;
        end
    end

endmodule

// File: rtl/adc_sample_fmt.sv
module adc_sample_fmt
    import adc_fmt_pkg::*;
#(
    parameter  int SAMPLE_W = 12,
    localparam int OUT_W    = ((SAMPLE_W + 7) / 8) * 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic                fmt_en,
    input  logic                ob_sel,
    input  logic                sext_en,
    input  logic                dc_en,
    input  logic [15:0]         dc_ofs,
    output logic                out_valid,
    output logic [OUT_W-1:0]    out_data
);

    fmt_ctrl_t           ctrl;
    logic                cv_valid;
    logic [SAMPLE_W-1:0] cv_data;
    pad_mode_e           cv_pad;
    logic                cv_dc_on;
    logic [OFS_W-1:0]    cv_ofs;

    always_comb begin
        ctrl.fmt_en  = fmt_en;
        ctrl.ob_sel  = ob_sel;
        ctrl.sext_en = sext_en;
        ctrl.dc_en   = dc_en;
        ctrl.dc_ofs  = dc_ofs;
    end

    adc_fmt_conv #(.SAMPLE_W(SAMPLE_W)) u_conv (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .ctrl     (ctrl),
        .cv_valid (cv_valid),
        .cv_data  (cv_data),
        .cv_pad   (cv_pad),
        .cv_dc_on (cv_dc_on),
        .cv_ofs   (cv_ofs)
    );

    adc_ofs_sat #(.SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) u_ofs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cv_valid  (cv_valid),
        .cv_data   (cv_data),
        .cv_pad    (cv_pad),
        .cv_dc_on  (cv_dc_on),
        .cv_ofs    (cv_ofs),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/adc_sample_fmt_chk.sv
module adc_sample_fmt_chk #(
    parameter int SAMPLE_W = 12,
    parameter int OUT_W    = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] in_data,
    input logic                fmt_en,
    input logic                dc_en,
    input logic                out_valid,
    input logic [OUT_W-1:0]    out_data
);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && out_data == '0));

    // R2
    strobe_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R2
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R10
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

    // R3
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !fmt_en && !dc_en) |-> ##2 (out_data[SAMPLE_W-1:0] == $past(in_data, 2)));

    generate
        if (OUT_W > SAMPLE_W) begin : g_padchk
            // R5
            pad_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (out_data[OUT_W-1:SAMPLE_W] == '0 ||
                               (&out_data[OUT_W-1:SAMPLE_W] && out_data[SAMPLE_W-1])));
        end
    endgenerate

endmodule

bind adc_sample_fmt adc_sample_fmt_chk #(.SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .fmt_en    (fmt_en),
    .dc_en     (dc_en),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/tb_adc_sample_fmt.sv
module tb_adc_sample_fmt;

    localparam int CLK_PERIOD = 10;
    localparam int SW   = 12;
    localparam int OW   = 16;
    localparam int MASK = (1 << SW) - 1;
    localparam int HALF = 1 << (SW - 1);
    localparam int PADM = ((1 << OW) - 1) ^ MASK;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_data = '0;
    logic          fmt_en = 1'b0, ob_sel = 1'b0, sext_en = 1'b0, dc_en = 1'b0;
    logic [15:0]   dc_ofs = '0;
    logic          out_valid;
    logic [OW-1:0] out_data;

    int    errors = 0;
    int    checks = 0;
    string cur_tag = "R2";

    // pipeline reference model
    bit    m1_v = 0, mo_v = 0;
    int    m1_val = 0, mo_val = 0;
    string m1_tag = "R2", mo_tag = "R10";

    adc_sample_fmt #(.SAMPLE_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .fmt_en(fmt_en), .ob_sel(ob_sel), .sext_en(sext_en), .dc_en(dc_en),
        .dc_ofs(dc_ofs), .out_valid(out_valid), .out_data(out_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int expect_word(int raw, bit f, bit o, bit x, bit d, int ofs);
        int v, s, so;
        v = raw & MASK;
        if (f && o) v = v ^ HALF;
        s = (v >= HALF) ? v - (1 << SW) : v;
        if (d && ofs != 0) begin
            so = (ofs >= 32768) ? ofs - 65536 : ofs;
            s = s + so;
            if (s > HALF - 1) s = HALF - 1;
            if (s < -HALF) s = -HALF;
        end
        v = s & MASK;
        if (f && !o && x && s < 0) v = v | PADM;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m1_v <= 0; mo_v <= 0; mo_val <= 0;
        end else begin
            m1_v <= in_valid;
            if (in_valid) begin
                m1_val <= expect_word(int'(in_data), fmt_en, ob_sel, sext_en, dc_en, int'(dc_ofs));
                m1_tag <= cur_tag;
            end
            mo_v <= m1_v;
            if (m1_v) begin
                mo_val <= m1_val;
                mo_tag <= m1_tag;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (out_valid !== mo_v) begin
                errors++;
                $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, mo_v);
            end
            checks++;
            if (out_data !== OW'(mo_val)) begin
                errors++;
                $display("FAIL %s out_data actual=%h expected=%h", mo_v ? mo_tag : "R10",
                         out_data, OW'(mo_val));
            end
        end
    end

    task automatic send(input int raw, input bit f, input bit o, input bit x,
                        input bit d, input int ofs, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_data = SW'(raw);
        fmt_en = f; ob_sel = o; sext_en = x; dc_en = d; dc_ofs = 16'(ofs);
        cur_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_data = SW'(i * 37 + 5); dc_ofs = 16'h5a5a;
            fmt_en = i[0]; sext_en = 1'b1;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            errors++;
            $display("FAIL R1 reset actual=%0b/%h expected=0/0000", out_valid, out_data);
        end
        rst_n = 1'b1;
        idle(2);
        // R3: conversion off, selects ignored
        send(12'hABC, 0, 1, 1, 0, 0, "R3");
        send(12'h123, 0, 0, 1, 0, 0, "R3");
        send(12'h900, 0, 0, 1, 0, 0, "R3");
        idle(3);
        // R4: offset binary
        send(12'h000, 1, 1, 1, 0, 0, "R4");
        send(12'hFFF, 1, 1, 1, 0, 0, "R4");
        send(12'h800, 1, 1, 0, 0, 0, "R4");
        send(12'h7FF, 1, 1, 1, 0, 0, "R4");
        idle(2);
        // R5 / R6: sign extension on and off
        send(12'h900, 1, 0, 1, 0, 0, "R5");
        send(12'h7FF, 1, 0, 1, 0, 0, "R5");
        send(12'hFFF, 1, 0, 1, 0, 0, "R5");
        send(12'h900, 1, 0, 0, 0, 0, "R6");
        send(12'hFFF, 1, 0, 0, 0, 0, "R6");
        idle(2);
        // R7: offset addition
        send(12'h100, 1, 0, 1, 1, 16'h0010, "R7");
        send(12'h100, 1, 0, 1, 1, 16'hFFFB, "R7");
        send(12'h002, 1, 0, 1, 1, 16'hFFF0, "R7");
        send(12'h000, 1, 1, 0, 1, 16'h0003, "R7");
        idle(1);
        // R8: clamping at both limits
        send(12'h7F0, 1, 0, 1, 1, 100, "R8");
        send(12'h810, 1, 0, 1, 1, 16'hFF9C, "R8");
        send(12'h000, 1, 0, 1, 1, 16'h7FFF, "R8");
        send(12'h000, 1, 0, 1, 1, 16'h8000, "R8");
        send(12'h7FF, 0, 0, 0, 1, 16'h0001, "R8");
        idle(2);
        // R9: offset ignored when disabled, zero offset neutral
        send(12'h456, 1, 0, 1, 0, 16'h1234, "R9");
        send(12'h856, 1, 0, 1, 0, 16'h7FFF, "R9");
        send(12'h856, 1, 0, 1, 1, 16'h0000, "R9");
        idle(4);
        // R2 / R10: stream with gaps
        for (int k = 0; k < 40; k++) begin
            send((k * 523) & MASK, k[0], k[1], k[2], k[3], (k * 4099) & 16'hFFFF, "R2");
            if (k % 7 == 3) idle(k % 3 + 1);
        end
        idle(5);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule